// File: doc/BRIEF.md
# Flash Command Sequence Interpreter

This block sits between a CPU bus and an embedded 16-bit flash array. The array is modelled here as registers. Bus reads go straight to the array while the block is idle. Bus writes never change the array directly. Instead, they are matched against multi-cycle unlock sequences, and a complete sequence starts one of two internal operations. The first is a timed half-word program, which can only clear bits. The second is a chip erase, which is handed to a sweeping erase sequencer that sets every word to all ones.

While an operation runs, the block raises `busy` and ignores every bus write. Reads during that time do not return array contents. They return a polling status word instead. During a program, bit 7 of that word is the complement of bit 7 of the data being programmed. During an erase, it reads as 0. Once bit 7 of a read matches what was written, the operation has finished and the block is back in read mode.

Top module: `flash_cmd_seq`

## Requirements
- R1: After a synchronous reset, `busy` is low and the block is in read mode: a read needs no preceding command.
- R2: A read strobe (`bus_rd` high at a rising edge) while idle presents the stored word at the strobed address on `rd_data` in the next cycle.
- R3: A program runs on four writes: address 0x555 with data 0xAA, address 0x2AA with data 0x55, address 0x555 with data 0xA0, then the target address with the data word. `busy` is high for exactly PROG_CYC cycles, starting the cycle after the fourth write. The word is written at the end of that window.
- R4: A program stores old AND new, so no bit can change from 0 to 1.
- R5: While `busy` is high, every bus write is ignored. It changes no array word, starts no operation and does not advance the sequence decoder.
- R6: A read while a program runs returns a status word. Bit 7 is the complement of bit 7 of the data being programmed, and all other bits are 0. After `busy` falls, reads return array words again.
- R7: A chip erase runs on six writes: 0x555/0xAA, 0x2AA/0x55, 0x555/0x80, 0x555/0xAA, 0x2AA/0x55, 0x555/0x10. `busy` is then high for 2^ADDR_W cycles, status reads return 0x0000 during that time, and every word reads 0xFFFF afterwards.
- R8: A write that does not match the expected step of a sequence, including 0xF0 (read/reset), returns the decoder to read mode. The array is left unchanged, and the next sequence must start again from its first step.
- R9: A reset asserted while a program runs ends `busy` and leaves the target word at its old value.
- R10: Command matching uses only the low 8 data bits. The upper data byte of unlock and command writes is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 16 | Write data |
| rd_data | output | 16 | Read data, valid the cycle after a read strobe |
| busy | output | 1 | Program or erase in progress |

## Verification
The bench builds the block with ADDR_W = 11, the smallest width that holds the 0x555 and 0x2AA command addresses, and with PROG_CYC = 6. With 2048 words, a full chip erase and a complete read-back of the array both fit within the run. That puts both ends of the erase sweep and the top address 0x7FF within reach. A six-cycle program window is long enough for several status polls, for a reset in the middle of a program, and for a whole command sequence issued while `busy` is high.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  localparam int CMD_AW = 11;
  localparam int DW     = 16;

  localparam logic [CMD_AW-1:0] ADR_KEY1 = 11'h555;
  localparam logic [CMD_AW-1:0] ADR_KEY2 = 11'h2AA;

  localparam logic [7:0] KEY1     = 8'hAA;
  localparam logic [7:0] KEY2     = 8'h55;
  localparam logic [7:0] OP_PROG  = 8'hA0;
  localparam logic [7:0] OP_ESET  = 8'h80;
  localparam logic [7:0] OP_CHIP  = 8'h10;

  typedef enum logic [2:0] {
    S_READ,
    S_K1,
    S_K2,
    S_PSET,
    S_ESET,
    S_EK1,
    S_EK2
  } dec_state_t;
endpackage

// File: rtl/fcs_decoder.sv
module fcs_decoder
  import fcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              busy,
  input  logic [CMD_AW-1:0] cmd_addr,
  input  logic [7:0]        key,
  output logic              prog_go,
  output logic              erase_go
);
  dec_state_t state, nxt;
  logic at_k1, at_k2;

  assign at_k1 = (cmd_addr == ADR_KEY1);
  assign at_k2 = (cmd_addr == ADR_KEY2);

  always_comb begin
    nxt      = state;
    prog_go  = 1'b0;
    erase_go = 1'b0;
    if (wr && !busy) begin
      nxt = S_READ;
      unique case (state)
        S_READ: if (at_k1 && key == KEY1) nxt = S_K1;
        S_K1:   if (at_k2 && key == KEY2) nxt = S_K2;
        S_K2: begin
          if (at_k1 && key == OP_PROG)      nxt = S_PSET;
          else if (at_k1 && key == OP_ESET) nxt = S_ESET;
        end
        S_PSET: prog_go = 1'b1;
        S_ESET: if (at_k1 && key == KEY1) nxt = S_EK1;
        S_EK1:  if (at_k2 && key == KEY2) nxt = S_EK2;
        S_EK2:  if (at_k1 && key == OP_CHIP) erase_go = 1'b1;
        default: nxt = S_READ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || busy) state <= S_READ;
    else             state <= nxt;
  end

  // R5: no operation may be launched while one is running
  p_quiet_busy_r5: assert property (@(posedge clk) disable iff (rst)
    busy |-> !(prog_go || erase_go));

  // R8: a launch always leaves the decoder back in read mode
  p_back_to_read_r8: assert property (@(posedge clk) disable iff (rst)
    (prog_go || erase_go) |=> (state == S_READ));
endmodule

// File: rtl/fcs_prog.sv
module fcs_prog #(
  parameter int ADDR_W   = 11,
  parameter int DW       = 16,
  parameter int PROG_CYC = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [ADDR_W-1:0] go_addr,
  input  logic [DW-1:0]     go_data,
  input  logic [DW-1:0]     old_word,
  output logic              busy,
  output logic [ADDR_W-1:0] addr,
  output logic              tgt_b7,
  output logic              we,
  output logic [DW-1:0]     wdata
);
  localparam int CYC_EFF = (PROG_CYC < 2) ? 2 : PROG_CYC;
  localparam int CW      = (CYC_EFF > 2) ? $clog2(CYC_EFF) : 1;

  logic [CW-1:0] cnt;
  logic [DW-1:0] data;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (go) begin
      busy <= 1'b1;
      cnt  <= CW'(CYC_EFF - 1);
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (go) begin
      addr <= go_addr;
      data <= go_data;
    end
  end

  assign tgt_b7 = data[7];
  assign we     = busy && (cnt == '0) && !rst;
  assign wdata  = data & old_word;

  // R3: the target address holds for the whole program window
  p_hold_target_r3: assert property (@(posedge clk) disable iff (rst)
    (busy && !go) |=> $stable(addr));

  // R4: the committed word never raises a bit of the old word
  p_clear_only_r4: assert property (@(posedge clk) disable iff (rst)
    we |-> ((wdata & ~old_word) == '0));
endmodule

// File: rtl/fcs_erase.sv
module fcs_erase #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  output logic              busy,
  output logic [ADDR_W-1:0] addr,
  output logic              we
);
  localparam logic [ADDR_W-1:0] LAST = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      addr <= '0;
    end else if (go) begin
      busy <= 1'b1;
      addr <= '0;
    end else if (busy) begin
      if (addr == LAST) busy <= 1'b0;
      addr <= addr + 1'b1;
    end
  end

  assign we = busy && !rst;

  // R7: the sweep steps through consecutive word addresses
  p_sweep_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && !go && addr != LAST) |=> (busy && addr == $past(addr) + 1'b1));
endmodule

// File: rtl/fcs_array.sv
module fcs_array #(
  parameter int ADDR_W = 11,
  parameter int DW     = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DW-1:0]     wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DW-1:0]     q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) q <= mem[raddr];
  end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import fcs_pkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int PROG_CYC = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       rd_data,
  output logic              busy
);
  logic              prog_go, erase_go;
  logic              p_busy, p_we, p_b7;
  logic [ADDR_W-1:0] p_addr;
  logic [DW-1:0]     p_wdata;
  logic              e_busy, e_we;
  logic [ADDR_W-1:0] e_addr;
  logic              m_we, m_re;
  logic [ADDR_W-1:0] m_waddr, m_raddr;
  logic [DW-1:0]     m_wdata, m_q;
  logic              rd_stat_q;
  logic [DW-1:0]     stat_q;

  assign busy = p_busy | e_busy;

  fcs_decoder u_dec (
    .clk      (clk),
    .rst      (rst),
    .wr       (bus_wr),
    .busy     (busy),
    .cmd_addr (bus_addr[CMD_AW-1:0]),
    .key      (bus_wdata[7:0]),
    .prog_go  (prog_go),
    .erase_go (erase_go)
  );

  fcs_prog #(.ADDR_W(ADDR_W), .DW(DW), .PROG_CYC(PROG_CYC)) u_prog (
    .clk      (clk),
    .rst      (rst),
    .go       (prog_go),
    .go_addr  (bus_addr),
    .go_data  (bus_wdata),
    .old_word (m_q),
    .busy     (p_busy),
    .addr     (p_addr),
    .tgt_b7   (p_b7),
    .we       (p_we),
    .wdata    (p_wdata)
  );

  fcs_erase #(.ADDR_W(ADDR_W)) u_erase (
    .clk  (clk),
    .rst  (rst),
    .go   (erase_go),
    .busy (e_busy),
    .addr (e_addr),
    .we   (e_we)
  );

  assign m_we    = e_busy ? e_we   : p_we;
  assign m_waddr = e_busy ? e_addr : p_addr;
  assign m_wdata = e_busy ? {DW{1'b1}} : p_wdata;
  assign m_re    = busy || bus_rd;
  assign m_raddr = p_busy ? p_addr : bus_addr;

  fcs_array #(.ADDR_W(ADDR_W), .DW(DW)) u_mem (
    .clk   (clk),
    .we    (m_we),
    .waddr (m_waddr),
    .wdata (m_wdata),
    .re    (m_re),
    .raddr (m_raddr),
    .q     (m_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_stat_q <= 1'b0;
      stat_q    <= '0;
    end else if (bus_rd) begin
      rd_stat_q <= busy;
      stat_q    <= p_busy ? {8'h00, ~p_b7, 7'h00} : '0;
    end
  end

  assign rd_data = rd_stat_q ? stat_q : m_q;

  // R3: the data write of a program sequence raises busy next cycle
  p_prog_start_r3: assert property (@(posedge clk) disable iff (rst)
    prog_go |=> p_busy);

  // R7: the erase command raises busy next cycle
  p_erase_start_r7: assert property (@(posedge clk) disable iff (rst)
    erase_go |=> e_busy);

  // R5: program and erase never overlap
  p_one_op_r5: assert property (@(posedge clk) disable iff (rst)
    !(p_busy && e_busy));

  // R9: reset always clears the busy flag
  p_reset_idle_r9: assert property (@(posedge clk)
    rst |=> !busy);
endmodule

// File: tb/sim_flash_cmd_seq.sv
`timescale 1ns/1ps
module sim_flash_cmd_seq;
  localparam int AW    = 11;
  localparam int PC    = 6;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [15:0]   bus_wdata = '0;
  logic [15:0]   rd_data;
  logic          busy;

  always #2.5 clk = ~clk;

  flash_cmd_seq #(.ADDR_W(AW), .PROG_CYC(PC)) u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rd_data(rd_data), .busy(busy)
  );

  int    total = 0;
  int    bad = 0;
  string cur_req = "R1";
  bit    done = 0;

  // reference model state
  logic [15:0] shadow [DEPTH];
  int          pcnt = 0, ecnt = 0;
  int          ptgt_a = 0;
  logic [15:0] ptgt_d = '0;
  int          hq_a[$];
  int          hq_d[$];
  bit          rd_pend = 0;
  logic [15:0] exp_rd = '0;

  int pat_a [6] = '{'h555, 'h2AA, 'h555, 'h555, 'h2AA, 'h555};
  int pat_e [6] = '{'hAA, 'h55, 'h80, 'hAA, 'h55, 'h10};
  int pat_p [3] = '{'hAA, 'h55, 'hA0};

  function automatic bit prog_prefix();
    if (hq_a.size() > 4) return 0;
    for (int i = 0; i < hq_a.size() && i < 3; i++)
      if (hq_a[i] != pat_a[i] || hq_d[i] != pat_p[i]) return 0;
    return 1;
  endfunction

  function automatic bit erase_prefix();
    if (hq_a.size() > 6) return 0;
    for (int i = 0; i < hq_a.size(); i++)
      if (hq_a[i] != pat_a[i] || hq_d[i] != pat_e[i]) return 0;
    return 1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      pcnt = 0; ecnt = 0; rd_pend = 0;
      hq_a.delete(); hq_d.delete();
    end else begin
      bit pre_busy;
      pre_busy = (pcnt > 0) || (ecnt > 0);
      rd_pend = bus_rd;
      if (bus_rd) begin
        if (pcnt > 0)      exp_rd = {8'h00, ~ptgt_d[7], 7'h00};
        else if (ecnt > 0) exp_rd = 16'h0000;
        else               exp_rd = shadow[bus_addr];
      end
      if (pcnt > 0) begin
        pcnt--;
        if (pcnt == 0) shadow[ptgt_a] = shadow[ptgt_a] & ptgt_d;
      end
      if (ecnt > 0) begin
        ecnt--;
        if (ecnt == 0) for (int i = 0; i < DEPTH; i++) shadow[i] = 16'hFFFF;
      end
      if (pre_busy) begin
        hq_a.delete(); hq_d.delete();
      end else if (bus_wr) begin
        bit pm, em;
        hq_a.push_back(int'(bus_addr));
        hq_d.push_back(int'(bus_wdata[7:0]));
        pm = prog_prefix();
        em = erase_prefix();
        if (pm && hq_a.size() == 4) begin
          pcnt = PC; ptgt_a = int'(bus_addr); ptgt_d = bus_wdata;
          hq_a.delete(); hq_d.delete();
        end else if (em && hq_a.size() == 6) begin
          ecnt = DEPTH;
          hq_a.delete(); hq_d.delete();
        end else if (!pm && !em) begin
          hq_a.delete(); hq_d.delete();
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(busy == ((pcnt > 0) || (ecnt > 0)), cur_req, "busy",
          16'(busy), 16'((pcnt > 0) || (ecnt > 0)));
      if (rd_pend) chk(rd_data == exp_rd, cur_req, "rd_data", rd_data, exp_rd);
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wr(input int a, input int d);
    bus_addr = AW'(a); bus_wdata = 16'(d); bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a);
    bus_addr = AW'(a); bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rd_expect(input int a, input logic [15:0] exp, input string req);
    rd(a);
    chk(rd_data == exp, req, "direct read", rd_data, exp);
  endtask

  task automatic prog(input int a, input int d);
    wr('h555, 'hAA); wr('h2AA, 'h55); wr('h555, 'hA0); wr(a, d);
  endtask

  task automatic erase_all();
    wr('h555, 'hAA); wr('h2AA, 'h55); wr('h555, 'h80);
    wr('h555, 'hAA); wr('h2AA, 'h55); wr('h555, 'h10);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cur_req = "R1";
    chk(busy == 1'b0, "R1", "busy after reset", 16'(busy), 16'h0);

    // R7: chip erase, status during sweep, contents after
    cur_req = "R7";
    erase_all();
    chk(busy == 1'b1, "R7", "busy after erase cmd", 16'(busy), 16'h1);
    repeat (5) @(negedge clk);
    rd_expect('h100, 16'h0000, "R7");
    wait_idle();
    rd_expect('h000, 16'hFFFF, "R7");
    rd_expect('h7FF, 16'hFFFF, "R7");

    // R3 / R6: program with polling
    cur_req = "R3";
    prog('h010, 'h1234);
    cur_req = "R6";
    rd_expect('h010, 16'h0080, "R6");
    rd_expect('h3FF, 16'h0080, "R6");
    wait_idle();
    cur_req = "R2";
    rd_expect('h010, 16'h1234, "R3");
    cur_req = "R6";
    prog('h7FF, 'h00F0);
    rd_expect('h7FF, 16'h0000, "R6");
    wait_idle();
    rd_expect('h7FF, 16'h00F0, "R3");
    cur_req = "R3";
    prog('h000, 'hA5A5);
    wait_idle();
    rd_expect('h000, 16'hA5A5, "R3");

    // R4: AND semantics
    cur_req = "R4";
    prog('h010, 'hFF00);
    wait_idle();
    rd_expect('h010, 16'h1200, "R4");

    // R5: writes during a program are ignored
    cur_req = "R5";
    prog('h020, 'h0F0F);
    prog('h021, 'h0000);
    wr('h021, 'h0000);
    wait_idle();
    rd_expect('h021, 16'hFFFF, "R5");
    rd_expect('h020, 16'h0F0F, "R5");
    wr('h021, 'h0000);
    @(negedge clk);
    chk(busy == 1'b0, "R5", "decoder not advanced", 16'(busy), 16'h0);
    rd_expect('h021, 16'hFFFF, "R5");

    // R8: broken sequences and read/reset
    cur_req = "R8";
    wr('h555, 'hAA); wr('h2AA, 'h55); wr('h555, 'h33); wr('h030, 'h0000);
    @(negedge clk);
    rd_expect('h030, 16'hFFFF, "R8");
    wr('h555, 'hAA); wr('h555, 'hF0); wr('h555, 'hA0); wr('h031, 'h0000);
    rd_expect('h031, 16'hFFFF, "R8");
    wr('h555, 'hAA); wr('h2AA, 'h55); wr('h555, 'h80); wr('h555, 'hAA);
    wr('h2AA, 'h55); wr('h554, 'h10);
    @(negedge clk);
    chk(busy == 1'b0, "R8", "no erase on bad address", 16'(busy), 16'h0);
    rd_expect('h010, 16'h1200, "R8");

    // R10: upper data byte ignored for commands
    cur_req = "R10";
    prog('h040, 'h5678);
    chk(busy == 1'b1, "R10", "plain program busy", 16'(busy), 16'h1);
    wait_idle();
    wr('h555, 'h12AA); wr('h2AA, 'h3455); wr('h555, 'h56A0); wr('h041, 'hC3C3);
    chk(busy == 1'b1, "R10", "program with upper bytes", 16'(busy), 16'h1);
    wait_idle();
    rd_expect('h041, 16'hC3C3, "R10");

    // R9: reset during program
    cur_req = "R9";
    prog('h050, 'h0000);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(busy == 1'b0, "R9", "busy after abort", 16'(busy), 16'h0);
    rd_expect('h050, 16'hFFFF, "R9");

    // R7 / R2: second erase and full read-back
    cur_req = "R7";
    erase_all();
    wait_idle();
    cur_req = "R2";
    for (int i = 0; i < DEPTH; i++) rd(i);
    @(negedge clk);
    rd_expect('h041, 16'hFFFF, "R7");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule